// File: doc/BRIEF.md
# Conflict-Free Memory Bank Picker

This block chooses a storage bank for every fixed-size packet that enters a packet buffer built from several slow DRAM banks working in parallel. Time is divided into frames of `B` slots, and one bank operation takes a whole frame. The departure frame of each packet is known when the packet arrives. The picker therefore chooses a bank that is free in three ways. No other arrival in the same frame has taken that bank. The bank has no read due in the current frame. The bank has no other read due in the frame in which this packet must be read back.

The picker holds a reservation vector that marks the banks already given out in the current frame. It also holds a bitmap of pending reads with one row per future frame, kept as a ring indexed by frame number modulo the row count. Each request combines the vector with two bitmap rows, takes the lowest-numbered bank that is free in all three, and records the choice. There are `3B-1` banks. Because at most `B` packets arrive per frame, a free bank always exists. A fail flag covers inputs that break that rule.

Top module: `dram_bank_picker`

## Requirements
- R1: The picker manages `3*B-1` banks, and any granted bank index is below that count.
- R2: A bank already granted in the current frame is not granted again before the next frame start.
- R3: A bank whose bitmap row for the current frame has its bit set is not granted.
- R4: A bank whose bitmap row for the departure frame has its bit set is not granted.
- R5: Among the banks that pass R2 to R4, the one with the lowest index is granted.
- R6: A grant marks the bank in the reservation vector and in the departure frame's bitmap row, and later requests see both marks.
- R7: When `frame_start` is high, the reservation vector is emptied, and a request in that same cycle is checked against an empty vector.
- R8: When `frame_start` is high, the bitmap row of frame `cur_frame-1` is cleared.
- R9: When no bank passes R2 to R4, `sel_fail` is raised instead of `sel_valid`, and no state changes.
- R10: The result appears on the registered outputs one cycle after the request. With no request, both `sel_valid` and `sel_fail` are low, and the two are never high together.
- R11: A synchronous active-low reset clears the outputs, the reservation vector and the whole bitmap.
- R12: Frame numbers wrap modulo `2**FRAME_W`, and the bitmap row of a frame is its number modulo `ROWS`. The design assumes `dep_frame-cur_frame` (modulo the frame range) lies between 0 and `ROWS-2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | High in the first slot of each frame |
| cur_frame | input | FRAME_W | Number of the current frame |
| req_valid | input | 1 | An arriving packet needs a bank |
| dep_frame | input | FRAME_W | Frame in which the packet must be read |
| sel_valid | output | 1 | A bank was granted for last cycle's request |
| sel_fail | output | 1 | No compatible bank for last cycle's request |
| sel_bank | output | BANK_W | Granted bank index, meaningful with `sel_valid` |

## Verification
The bench builds the picker with `B=2`, which gives five banks, eight bitmap rows and a four-bit frame number. With only five banks, a few requests fill the reservation vector and bitmap rows completely, so the fail path and the lowest-index search across partly filled rows are easy to reach. The four-bit frame counter lets frame numbers wrap past 15 within a short run, which exercises the ring indexing. A request in a frame that already holds `B` grants drives the fail case on purpose.

// File: rtl/bank_pick_pkg.sv
// Shared types for the bank picker.
// Assumes nothing beyond standard SystemVerilog.
package bank_pick_pkg;

    // Outcome of one selection attempt
    typedef enum logic [1:0] {
        PICK_IDLE  = 2'd0,
        PICK_GRANT = 2'd1,
        PICK_FAIL  = 2'd2
    } pick_outcome_e;

endpackage

// File: rtl/resv_vector.sv
// Write-reservation vector: one bit per bank, marking the banks that have
// already been given an arriving packet in the current frame.
// Assumes start is high in the first slot of each frame; it empties the
// vector, and a set in that same cycle lands in the emptied vector.
module resv_vector #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          set_en,
    input  logic [NB-1:0] set_mask,
    output logic [NB-1:0] resv_eff,
    output logic [NB-1:0] resv_q
);

    logic [NB-1:0] base;

    // Contents as seen by a request in this cycle
    always_comb begin
        base     = start ? '0 : resv_q;
        resv_eff = base;
    end

    // Register the vector with the new reservation added
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= base | (set_en ? set_mask : '0);
        end
    end

endmodule

// File: rtl/read_bitmap.sv
// Read-transaction bitmap: a ring of ROWS rows, one per frame, each with one
// bit per bank. A set bit means that bank holds a packet to be read in that
// frame. Two read ports are provided (current and departure rows), plus one
// clear and one set port.
// Assumes ROWS is a power of two. A set and a clear on the same row in one
// cycle leave only the set bits.
module read_bitmap #(
    parameter int NB    = 8,
    parameter int ROWS  = 16,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [ROW_W-1:0] dep_row,
    input  logic             clr_en,
    input  logic [ROW_W-1:0] clr_row,
    input  logic             set_en,
    input  logic [ROW_W-1:0] set_row,
    input  logic [NB-1:0]    set_mask,
    output logic [NB-1:0]    cur_bits,
    output logic [NB-1:0]    dep_bits
);

    logic [ROWS-1:0][NB-1:0] rows_flat;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic          hit_clr;
        logic          hit_set;
        logic [NB-1:0] row_q;

        // Decode whether this row is addressed this cycle
        always_comb begin
            hit_clr = clr_en && (clr_row == ROW_W'(r));
            hit_set = set_en && (set_row == ROW_W'(r));
        end

        // Update the row: clear first, then set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (hit_set) begin
                row_q <= (hit_clr ? '0 : row_q) | set_mask;
            end else if (hit_clr) begin
                row_q <= '0;
            end
        end

        assign rows_flat[r] = row_q;
    end

    // Read both rows needed by the compatibility check
    always_comb begin
        cur_bits = rows_flat[cur_row];
        dep_bits = rows_flat[dep_row];
    end

endmodule

// File: rtl/lowest_free.sv
// Priority encoder: finds the lowest-index set bit of a free-bank vector and
// returns it both as an index and as a one-hot mask.
// Assumes BANK_W is wide enough to hold NB-1.
module lowest_free #(
    parameter int NB     = 8,
    parameter int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0]     free_vec,
    output logic              found,
    output logic [BANK_W-1:0] idx,
    output logic [NB-1:0]     mask
);

    // Scan from the top down so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                idx = BANK_W'(i);
            end
        end
        found = |free_vec;
    end

    // One-hot form of the chosen bank
    always_comb begin
        mask = found ? (NB'(1) << idx) : '0;
    end

endmodule

// File: rtl/dram_bank_picker.sv
// Top of the bank picker. For each request it forms the set of banks not
// reserved in this frame, not read in this frame and not read in the
// departure frame, then grants the lowest of them and records the grant.
// Assumes at most B requests per frame and a departure distance between 0
// and ROWS-2 frames. The result is registered: one cycle of latency.
module dram_bank_picker #(
    parameter int B       = 3,
    parameter int ROWS    = 16,
    parameter int FRAME_W = 8,
    parameter int NB      = 3 * B - 1,
    parameter int BANK_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [FRAME_W-1:0] cur_frame,
    input  logic               req_valid,
    input  logic [FRAME_W-1:0] dep_frame,
    output logic               sel_valid,
    output logic               sel_fail,
    output logic [BANK_W-1:0]  sel_bank
);

    import bank_pick_pkg::*;

    localparam int ROW_W = $clog2(ROWS);

    logic [ROW_W-1:0]  cur_row;
    logic [ROW_W-1:0]  dep_row;
    logic [ROW_W-1:0]  prev_row;
    logic [NB-1:0]     resv_eff;
    logic [NB-1:0]     resv_q;
    logic [NB-1:0]     cur_bits;
    logic [NB-1:0]     dep_bits;
    logic [NB-1:0]     free_vec;
    logic              found;
    logic [BANK_W-1:0] pick_idx;
    logic [NB-1:0]     pick_mask;
    logic              grant;
    pick_outcome_e     outcome;

    // Map frame numbers onto bitmap rows
    always_comb begin
        cur_row  = cur_frame[ROW_W-1:0];
        dep_row  = dep_frame[ROW_W-1:0];
        prev_row = cur_row - ROW_W'(1);
    end

    resv_vector #(.NB(NB)) resv_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frame_start),
        .set_en   (grant),
        .set_mask (pick_mask),
        .resv_eff (resv_eff),
        .resv_q   (resv_q)
    );

    read_bitmap #(.NB(NB), .ROWS(ROWS), .ROW_W(ROW_W)) rmap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_row  (cur_row),
        .dep_row  (dep_row),
        .clr_en   (frame_start),
        .clr_row  (prev_row),
        .set_en   (grant),
        .set_row  (dep_row),
        .set_mask (pick_mask),
        .cur_bits (cur_bits),
        .dep_bits (dep_bits)
    );

    // Banks free of all three conflict kinds
    always_comb begin
        free_vec = ~(resv_eff | cur_bits | dep_bits);
    end

    lowest_free #(.NB(NB), .BANK_W(BANK_W)) enc_i (
        .free_vec (free_vec),
        .found    (found),
        .idx      (pick_idx),
        .mask     (pick_mask)
    );

    // Classify this cycle's request
    always_comb begin
        if (!req_valid) begin
            outcome = PICK_IDLE;
        end else if (found) begin
            outcome = PICK_GRANT;
        end else begin
            outcome = PICK_FAIL;
        end
        grant = (outcome == PICK_GRANT);
    end

    // Register the result for the requester
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid <= 1'b0;
            sel_fail  <= 1'b0;
            sel_bank  <= '0;
        end else begin
            sel_valid <= (outcome == PICK_GRANT);
            sel_fail  <= (outcome == PICK_FAIL);
            if (grant) begin
                sel_bank <= pick_idx;
            end
        end
    end

endmodule

// File: rtl/dram_bank_picker_chk.sv
// Property checker for the bank picker, attached by bind. Keeps its own
// record of the banks granted in each frame.
module dram_bank_picker_chk #(
    parameter int B       = 3,
    parameter int FRAME_W = 8,
    parameter int NB      = 3 * B - 1,
    parameter int BANK_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              req_valid,
    input logic              sel_valid,
    input logic              sel_fail,
    input logic [BANK_W-1:0] sel_bank
);

    logic          fs_q;
    logic [NB-1:0] seen;

    // Track the frame boundary and the grants seen since it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
            seen <= '0;
        end else begin
            fs_q <= frame_start;
            if (fs_q) begin
                seen <= sel_valid ? (NB'(1) << sel_bank) : '0;
            end else if (sel_valid) begin
                seen <= seen | (NB'(1) << sel_bank);
            end
        end
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_valid && sel_fail)); // R10

    AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!sel_valid && !sel_fail)); // R10

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (int'(sel_bank) < NB)); // R1

    AST_NO_REUSE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !fs_q) |-> !seen[sel_bank]); // R2

endmodule

bind dram_bank_picker dram_bank_picker_chk #(
    .B(B), .FRAME_W(FRAME_W), .NB(NB), .BANK_W(BANK_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .req_valid   (req_valid),
    .sel_valid   (sel_valid),
    .sel_fail    (sel_fail),
    .sel_bank    (sel_bank)
);

// File: tb/dram_bank_picker_tb_top.sv
`timescale 1ns/1ps
module dram_bank_picker_tb_top;

    localparam int B       = 2;
    localparam int ROWS    = 8;
    localparam int FRAME_W = 4;
    localparam int NB      = 3 * B - 1;
    localparam int BANK_W  = $clog2(NB);
    localparam int NVEC    = 16;

    typedef struct packed {
        logic       fs;
        logic       rq;
        logic [3:0] cur;
        logic [3:0] dep;
        logic       ev;
        logic       ef;
        logic [2:0] eb;
        logic [3:0] tag;
    } vec_t;

    // B=2: five banks. Each line's comment gives the state it relies on.
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 4'd0,  4'd3,  1'b1, 1'b0, 3'd0, 4'd5},  // R5 all free
        '{1'b0, 1'b1, 4'd0,  4'd3,  1'b1, 1'b0, 3'd1, 4'd2},  // R2 bank0 reserved
        '{1'b1, 1'b1, 4'd1,  4'd5,  1'b1, 1'b0, 3'd0, 4'd7},  // R7 new frame empties W
        '{1'b0, 1'b1, 4'd1,  4'd3,  1'b1, 1'b0, 3'd2, 4'd4},  // R4 row3 holds 0,1
        '{1'b1, 1'b1, 4'd2,  4'd5,  1'b1, 1'b0, 3'd1, 4'd6},  // R6 row5 holds 0
        '{1'b1, 1'b1, 4'd3,  4'd5,  1'b1, 1'b0, 3'd3, 4'd3},  // R3 row3 holds 0,1,2
        '{0, 1'b1, 4'd3,  4'd5,  1'b1, 1'b0, 3'd4, 4'd5},     // R5 only bank4 left
        '{1'b0, 1'b1, 4'd3,  4'd6,  1'b0, 1'b1, 3'd0, 4'd9},  // R9 W and row3 cover all
        '{1'b0, 1'b0, 4'd3,  4'd0,  1'b0, 1'b0, 3'd0, 4'd10}, // R10 no request
        '{1'b1, 1'b1, 4'd4,  4'd5,  1'b1, 1'b0, 3'd2, 4'd6},  // R6 row5 holds 0,1,3,4
        '{1'b1, 1'b1, 4'd5,  4'd7,  1'b0, 1'b1, 3'd0, 4'd9},  // R9 row5 full
        '{1'b1, 1'b1, 4'd6,  4'd11, 1'b1, 1'b0, 3'd0, 4'd8},  // R8 row3 was cleared
        '{1'b1, 1'b1, 4'd7,  4'd13, 1'b1, 1'b0, 3'd0, 4'd8},  // R8 row5 was cleared
        '{1'b1, 1'b1, 4'd12, 4'd13, 1'b1, 1'b0, 3'd1, 4'd5},  // R5 row5 holds 0
        '{1'b0, 1'b1, 4'd12, 4'd13, 1'b1, 1'b0, 3'd2, 4'd6},  // R6 W holds 1, row5 0,1
        '{1'b1, 1'b1, 4'd15, 4'd5,  1'b1, 1'b0, 3'd3, 4'd12}  // R12 wrap 15->5, row5 0,1,2
    };

    logic               clk;
    logic               rst_n;
    logic               frame_start;
    logic [FRAME_W-1:0] cur_frame;
    logic               req_valid;
    logic [FRAME_W-1:0] dep_frame;
    logic               sel_valid;
    logic               sel_fail;
    logic [BANK_W-1:0]  sel_bank;

    int n_checks;
    int n_fails;
    bit done;

    dram_bank_picker #(.B(B), .ROWS(ROWS), .FRAME_W(FRAME_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cur_frame   (cur_frame),
        .req_valid   (req_valid),
        .dep_frame   (dep_frame),
        .sel_valid   (sel_valid),
        .sel_fail    (sel_fail),
        .sel_bank    (sel_bank)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic fs, input logic rq,
                         input logic [3:0] cur, input logic [3:0] dep);
        frame_start = fs;
        req_valid   = rq;
        cur_frame   = cur;
        dep_frame   = dep;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        drive(1'b0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        // R11: outputs are quiet in reset
        check("R11 valid after reset", int'(sel_valid), 0);
        check("R11 fail after reset", int'(sel_fail), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].fs, VEC[i].rq, VEC[i].cur, VEC[i].dep);
            @(negedge clk);
            // R10: result one cycle after the request
            check($sformatf("R%0d vec%0d valid", VEC[i].tag, i), int'(sel_valid), int'(VEC[i].ev));
            check($sformatf("R%0d vec%0d fail", VEC[i].tag, i), int'(sel_fail), int'(VEC[i].ef));
            if (VEC[i].ev) begin
                check($sformatf("R%0d vec%0d bank", VEC[i].tag, i), int'(sel_bank), int'(VEC[i].eb));
            end
        end

        // R11: reset mid-run empties the bitmap (row5 held 0,1,2,3)
        drive(1'b0, 1'b0, 4'd15, 4'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 valid in reset", int'(sel_valid), 0);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 4'd15, 4'd5);
        @(negedge clk);
        check("R11 valid after clear", int'(sel_valid), 1);
        check("R11 bank after clear", int'(sel_bank), 0);

        // R1: with all five banks free in W, fifth grant in one frame is bank 4
        drive(1'b1, 1'b1, 4'd0, 4'd1);
        @(negedge clk);
        drive(1'b0, 1'b1, 4'd0, 4'd2);
        @(negedge clk);
        drive(1'b0, 1'b1, 4'd0, 4'd3);
        @(negedge clk);
        drive(1'b0, 1'b1, 4'd0, 4'd4);
        @(negedge clk);
        drive(1'b0, 1'b1, 4'd0, 4'd6);
        @(negedge clk);
        check("R1 highest bank valid", int'(sel_valid), 1);
        check("R1 highest bank index", int'(sel_bank), NB - 1);
        drive(1'b0, 1'b1, 4'd0, 4'd6);
        @(negedge clk);
        check("R1 no bank beyond count", int'(sel_fail), 1);
        drive(1'b0, 1'b0, 4'd0, 4'd0);
        @(negedge clk);
        check("R10 idle after fail", int'(sel_fail), 0);

        finish_run();
    end

    initial begin
        #(20.0 * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule